// File: doc/BRIEF.md
# FIFO Panic Watermark Controller

This block sits between a memory fetch path and a display scan-out path. It holds a small pixel FIFO. Fetched beats enter on the write side, and pixels leave on the read side during active scan-out. The block watches the registered fill count and raises a panic flag with hysteresis. The system interconnect uses that flag to grant the display engine a higher refill priority.

Two 2-bit watermark codes set the band. Each code names a fraction of the FIFO depth: code 0 is empty, 1 is one third, 2 is two thirds and 3 is completely full. Panic rises when the fill count falls under the low level. It holds until the fill count reaches the high level. A separate enable input gates the flag. The block also drives a refill request whenever a 256-byte burst would fit into the free space. A sticky underflow flag records any read that was attempted on an empty FIFO.

Top module: `fifo_panic_ctrl`

## Requirements
- R1: Data leaves the FIFO in the order it was written, and `rd_data` always shows the oldest entry. A write while `fill_level` equals DEPTH is dropped. A read while `fill_level` is 0 is dropped. `fill_level` never exceeds DEPTH.
- R2: A cycle with an accepted write and an accepted read leaves `fill_level` unchanged.
- R3: The level for a code c is DEPTH*c/3, truncated. With DEPTH=48 the levels are 0, 16, 32 and 48. A pulse on `cfg_wr` loads both codes at once. With a low code of 0, panic never rises.
- R4: While enabled and not in panic, panic rises at the clock edge after `fill_level` is seen below the low level.
- R5: Once raised, panic stays high while `fill_level` is below the high level. It falls at the edge after `fill_level` is seen at or above the high level.
- R6: With a high code of 3, panic still falls once the FIFO is completely full.
- R7: While `panic_en` is 0, `panic` is 0 in the same cycle. Panic evaluation restarts from the clear state once the enable returns.
- R8: `req_prio` equals PANIC_PRIO (default 7) while `panic` is 1, and NORMAL_PRIO (default 2) otherwise.
- R9: `fetch_req` is 1 exactly when the free entries (DEPTH minus `fill_level`) can hold one burst of BURST_BYTES (256) bytes of DATA_W-bit beats. For 64-bit beats this is 32 beats, so `fill_level` must be at most 16.
- R10: New codes loaded at a clock edge are first compared at the following edge. `panic` changes only at clock edges.
- R11: `underflow` becomes 1 after any cycle where `rd_en` is high on an empty FIFO. It stays 1 until a cycle with `underflow_clr` high and no new underflow. A set and a clear in the same cycle leave it set.
- R12: Synchronous active-low reset empties the FIFO. It clears `panic` and `underflow` and restores the codes to low=1 and high=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write one fetched beat |
| wr_data | input | DATA_W | Fetched beat |
| rd_en | input | 1 | Pop one pixel beat |
| rd_data | output | DATA_W | Oldest stored beat |
| fill_level | output | $clog2(DEPTH+1) | Registered fill count |
| empty | output | 1 | FIFO holds nothing |
| full | output | 1 | FIFO holds DEPTH entries |
| cfg_wr | input | 1 | Load both watermark codes |
| cfg_low | input | 2 | Low watermark code |
| cfg_high | input | 2 | High watermark code |
| panic_en | input | 1 | Enable for the panic flag |
| panic | output | 1 | Panic flag with hysteresis |
| req_prio | output | PRIO_W | Priority level requested from the interconnect |
| fetch_req | output | 1 | A full burst fits in free space |
| underflow | output | 1 | Sticky read-on-empty flag |
| underflow_clr | input | 1 | Write-one-to-clear for `underflow` |

## Verification
The assertions assume that every input is synchronous and settled around the rising edge. They also assume that `wr_valid` and `rd_en` are ignored rather than rejected when the FIFO is full or empty. The hysteresis properties take the two thresholds as plain levels: they make no assumption that low is below high. They only check the rise, hold and release rules against the registered count.

The stimulus changes inputs only at the falling edge. It keeps to the default codes or to explicitly loaded ones. It deliberately pushes the FIFO into full-write and empty-read cases, so that the drop and underflow rules are exercised within the same assumptions.

// File: rtl/wm_pkg.sv
// Shared types and helpers for the FIFO panic watermark controller.
// Assumes watermark codes are 2 bits wide, each naming thirds of the depth.
package wm_pkg;

    typedef logic [1:0] wm_code_t;

    localparam wm_code_t WM_LOW_RST  = 2'd1;
    localparam wm_code_t WM_HIGH_RST = 2'd2;

    // Converts a fraction code into an entry count: depth*code/3, truncated.
    function automatic int unsigned wm_level(input int unsigned depth, input wm_code_t code);
        return (depth * 32'(code)) / 32'd3;
    endfunction

endpackage

// File: rtl/wm_fifo.sv
// Circular pixel FIFO with a registered fill count and show-ahead read data.
// Assumes writes on a full FIFO and reads on an empty FIFO are dropped.
module wm_fifo #(
    parameter int DEPTH  = 48,
    parameter int DATA_W = 64,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  count,
    output logic              empty,
    output logic              full,
    output logic              rd_empty_hit
);

    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              wr_ok, rd_ok;

    // Qualifies the requests against the current occupancy.
    always_comb begin
        wr_ok        = wr_valid && !full;
        rd_ok        = rd_en && !empty;
        rd_empty_hit = rd_en && empty;
    end

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign rd_data = mem[rd_ptr];

    // Stores an accepted beat at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_ptr] <= wr_data;
    end

    // Advances the pointers with wrap at the last entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (wr_ok) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_ok) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
        end
    end

    // Tracks occupancy; a paired read and write cancel out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else begin
            unique case ({wr_ok, rd_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));

    p_pair_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && rd_en && !empty && !full) |=> (count == $past(count)));

    p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !rd_en) |=> full);

endmodule

// File: rtl/wm_thresholds.sv
// Holds the two watermark codes and turns them into entry-count levels.
// Assumes codes are loaded together on a single-cycle strobe.
module wm_thresholds
    import wm_pkg::*;
#(
    parameter int DEPTH = 48,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  wm_code_t         cfg_low,
    input  wm_code_t         cfg_high,
    output logic [CNT_W-1:0] low_lvl,
    output logic [CNT_W-1:0] high_lvl
);

    wm_code_t low_code, high_code;

    // Registers the codes so new values reach the comparators a cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_code  <= WM_LOW_RST;
            high_code <= WM_HIGH_RST;
        end else if (cfg_wr) begin
            low_code  <= cfg_low;
            high_code <= cfg_high;
        end
    end

    // Maps the registered codes onto levels.
    always_comb begin
        low_lvl  = CNT_W'(wm_level(DEPTH, low_code));
        high_lvl = CNT_W'(wm_level(DEPTH, high_code));
    end

endmodule

// File: rtl/wm_panic.sv
// Hysteresis state for the panic flag, compared against the registered count.
// Assumes the levels are stable for the cycle they are sampled in.
module wm_panic #(
    parameter int DEPTH = 48,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] low_lvl,
    input  logic [CNT_W-1:0] high_lvl,
    output logic             panic_q
);

    // Raises below the low level, releases at or above the high level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            panic_q <= 1'b0;
        end else if (!en) begin
            panic_q <= 1'b0;
        end else if (panic_q) begin
            if (count >= high_lvl) panic_q <= 1'b0;
        end else if (count < low_lvl) begin
            panic_q <= 1'b1;
        end
    end

    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !panic_q && count < low_lvl) |=> panic_q);

    p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && panic_q && count >= high_lvl) |=> !panic_q);

    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en && panic_q && count < high_lvl) |=> panic_q);

    p_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !panic_q && count >= low_lvl) |=> !panic_q);

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !panic_q);

endmodule

// File: rtl/fifo_panic_ctrl.sv
// Top: scan-out FIFO plus panic watermark logic, priority select,
// burst refill request and sticky underflow flag.
// Assumes all inputs are synchronous to clk.
module fifo_panic_ctrl
    import wm_pkg::*;
#(
    parameter int DEPTH       = 48,
    parameter int DATA_W      = 64,
    parameter int BURST_BYTES = 256,
    parameter int PRIO_W      = 3,
    parameter int NORMAL_PRIO = 2,
    parameter int PANIC_PRIO  = 7,
    localparam int CNT_W       = $clog2(DEPTH + 1),
    localparam int BEAT_BYTES  = DATA_W / 8,
    localparam int BURST_BEATS = BURST_BYTES / BEAT_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  fill_level,
    output logic              empty,
    output logic              full,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_low,
    input  logic [1:0]        cfg_high,
    input  logic              panic_en,
    output logic              panic,
    output logic [PRIO_W-1:0] req_prio,
    output logic              fetch_req,
    output logic              underflow,
    input  logic              underflow_clr
);

    logic [CNT_W-1:0] low_lvl, high_lvl;
    logic             panic_q;
    logic             rd_empty_hit;

    wm_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (wr_valid),
        .wr_data      (wr_data),
        .rd_en        (rd_en),
        .rd_data      (rd_data),
        .count        (fill_level),
        .empty        (empty),
        .full         (full),
        .rd_empty_hit (rd_empty_hit)
    );

    wm_thresholds #(.DEPTH(DEPTH)) u_thr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_low  (cfg_low),
        .cfg_high (cfg_high),
        .low_lvl  (low_lvl),
        .high_lvl (high_lvl)
    );

    wm_panic #(.DEPTH(DEPTH)) u_panic (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (panic_en),
        .count    (fill_level),
        .low_lvl  (low_lvl),
        .high_lvl (high_lvl),
        .panic_q  (panic_q)
    );

    // Gates the registered flag and selects the requested priority.
    always_comb begin
        panic    = panic_q && panic_en;
        req_prio = panic ? PRIO_W'(PANIC_PRIO) : PRIO_W'(NORMAL_PRIO);
    end

    // Builds the refill request; a burst larger than the FIFO never fits.
    generate
        if (BURST_BEATS > DEPTH) begin : g_burst_too_big
            assign fetch_req = 1'b0;
        end else begin : g_burst_fits
            assign fetch_req = (fill_level <= CNT_W'(DEPTH - BURST_BEATS));
        end
    endgenerate

    // Keeps the underflow flag; a fresh underflow beats the clear strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)             underflow <= 1'b0;
        else if (rd_empty_hit)  underflow <= 1'b1;
        else if (underflow_clr) underflow <= 1'b0;
    end

    p_uflow_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty) |=> underflow);

    p_uflow_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (underflow && !underflow_clr) |=> underflow);

    p_prio_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(panic) |-> (req_prio != PRIO_W'(NORMAL_PRIO) || PANIC_PRIO == NORMAL_PRIO));

endmodule

// File: tb/fifo_panic_ctrl_bench.sv
`timescale 1ns/1ps
module fifo_panic_ctrl_bench;

    localparam int DEPTH  = 48;
    localparam int DATA_W = 64;
    localparam int CNT_W  = $clog2(DEPTH + 1);
    localparam int NSTEP  = 11;
    // Columns: write, read, repeat count, expected fill, expected panic, expected fetch_req.
    localparam int TBL [NSTEP][6] = '{
        '{1, 0, 10, 10, 1, 1},
        '{1, 0, 20, 30, 1, 0},
        '{1, 0,  2, 32, 0, 0},
        '{0, 1, 10, 22, 0, 0},
        '{0, 1,  6, 16, 0, 1},
        '{0, 1,  1, 15, 1, 1},
        '{1, 1,  5, 15, 1, 1},
        '{1, 0, 17, 32, 0, 0},
        '{1, 0, 20, 48, 0, 0},
        '{0, 1, 48,  0, 1, 1},
        '{0, 1,  3,  0, 1, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_valid = 1'b0, rd_en = 1'b0, cfg_wr = 1'b0, panic_en = 1'b1, underflow_clr = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [1:0] cfg_low = 2'd0, cfg_high = 2'd0;
    logic [DATA_W-1:0] rd_data;
    logic [CNT_W-1:0] fill_level;
    logic empty, full, panic, fetch_req, underflow;
    logic [2:0] req_prio;

    int n_chk = 0, n_err = 0;
    int mcnt = 0, wseq = 100, rseq = 100;
    bit done = 0;

    always #2.5 clk = ~clk;

    fifo_panic_ctrl u_fifo_panic_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_en(rd_en), .rd_data(rd_data), .fill_level(fill_level), .empty(empty),
        .full(full), .cfg_wr(cfg_wr), .cfg_low(cfg_low), .cfg_high(cfg_high),
        .panic_en(panic_en), .panic(panic), .req_prio(req_prio), .fetch_req(fetch_req),
        .underflow(underflow), .underflow_clr(underflow_clr)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One cycle of traffic; read data is checked against the bench's own order model.
    task automatic cyc(input bit w, input bit r, input bit c);
        bit aw, ar;
        @(negedge clk);
        wr_valid = w; rd_en = r; underflow_clr = c; wr_data = DATA_W'(wseq);
        aw = w && (mcnt < DEPTH);
        ar = r && (mcnt > 0);
        if (ar) chk("R1 data order", int'(rd_data[31:0]), rseq);
        @(posedge clk);
        #1;
        wr_valid = 1'b0; rd_en = 1'b0; underflow_clr = 1'b0;
        if (aw) begin mcnt++; wseq++; end
        if (ar) begin mcnt--; rseq++; end
    endtask

    task automatic run(input bit w, input bit r, input int n);
        for (int k = 0; k < n; k++) cyc(w, r, 1'b0);
    endtask

    // Idle cycle, then park at the falling edge for sampling.
    task automatic settle();
        cyc(1'b0, 1'b0, 1'b0);
        @(negedge clk);
    endtask

    task automatic load_cfg(input logic [1:0] l, input logic [1:0] h);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_low = l; cfg_high = h;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual 0 expected 1");
        finish_run();
    end

    initial begin
        // R12: state held in reset.
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R12 reset fill", int'(fill_level), 0);
        chk("R12 reset panic", int'(panic), 0);
        chk("R12 reset underflow", int'(underflow), 0);
        chk("R8 reset prio", int'(req_prio), 2);
        rst_n = 1'b1;

        // Table walk under default codes (levels 16 and 32).
        for (int i = 0; i < NSTEP; i++) begin
            run(TBL[i][0] != 0, TBL[i][1] != 0, TBL[i][2]);
            settle();
            chk("R1 R2 fill", int'(fill_level), TBL[i][3]);
            chk("R4 R5 panic", int'(panic), TBL[i][4]);
            chk("R9 fetch_req", int'(fetch_req), TBL[i][5]);
            chk("R8 prio", int'(req_prio), TBL[i][4] != 0 ? 7 : 2);
        end

        // R11: sticky flag, set wins over clear, then clear.
        chk("R11 sticky after empty read", int'(underflow), 1);
        cyc(1'b0, 1'b1, 1'b1);
        settle();
        chk("R11 set beats clear", int'(underflow), 1);
        cyc(1'b0, 1'b0, 1'b1);
        settle();
        chk("R11 cleared", int'(underflow), 0);

        // R7: enable gating is immediate, then evaluation restarts.
        panic_en = 1'b0;
        #1;
        chk("R7 gated same cycle", int'(panic), 0);
        chk("R8 gated prio", int'(req_prio), 2);
        settle();
        chk("R7 stays low", int'(panic), 0);
        @(negedge clk);
        panic_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk("R7 re-enable rises", int'(panic), 1);

        // R6: high code full still releases at full.
        load_cfg(2'd2, 2'd3);
        run(1'b1, 1'b0, 47);
        settle();
        chk("R6 fill 47", int'(fill_level), 47);
        chk("R6 held below full", int'(panic), 1);
        run(1'b1, 1'b0, 1);
        settle();
        chk("R6 released at full", int'(panic), 0);
        chk("R1 full flag", int'(full), 1);
        run(1'b1, 1'b0, 1);
        settle();
        chk("R1 full write dropped", int'(fill_level), 48);
        run(1'b0, 1'b1, 17);
        settle();
        chk("R3 R4 below level 32", int'(panic), 1);

        // R10: new codes compared from the following edge.
        load_cfg(2'd0, 2'd1);
        chk("R10 unchanged at load edge", int'(panic), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R10 release next edge", int'(panic), 0);

        // R3: low code 0 never raises panic.
        run(1'b0, 1'b1, 31);
        settle();
        settle();
        chk("R3 empty with low code 0", int'(fill_level), 0);
        chk("R3 no panic with low code 0", int'(panic), 0);

        // R12: reset mid-run restores defaults.
        cyc(1'b0, 1'b1, 1'b0);
        run(1'b1, 1'b0, 5);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk("R12 fill cleared", int'(fill_level), 0);
        chk("R12 underflow cleared", int'(underflow), 0);
        chk("R12 panic cleared", int'(panic), 0);
        rst_n = 1'b1;
        mcnt = 0;
        rseq = wseq;
        settle();
        chk("R12 R3 default low code restored", int'(panic), 1);
        chk("R9 fetch on empty", int'(fetch_req), 1);

        finish_run();
    end

endmodule